// File: doc/BRIEF.md
# Big-Endian Load/Store Alignment Unit

This block is the address and lane-steering stage that sits between a processor core and a data memory one word wide. For every memory access it adds a sign-extended 16-bit displacement to a base register value. It then masks the low address bits so that the address suits the access size. It also moves data between register layout and memory lanes. Lanes are big-endian: the lowest byte address within a word holds the most significant byte.

For a store, the low byte or halfword of the source register is copied into every lane of its size. A byte-enable mask then picks the lanes that are actually written. For a load, the addressed byte or halfword is taken from the returned memory word. It is widened to the full register width, with sign extension or zero extension as requested. The unit is purely combinational and holds no state. It has no streaming data path, so there is no valid/ready handshake and no back-pressure. Every output follows its inputs within the same cycle.

Top module: `lsa_unit`

## Requirements
- R1: `mem_addr_o` is formed from `base_i` plus `imm_i` sign-extended to 32 bits, modulo 2^32, before any alignment masking.
- R2: Size codes are 00 byte, 01 halfword, 10 word. A halfword clears address bit 0, a word clears address bits 1:0, and a byte keeps every address bit.
- R3: A byte store drives the low byte of `store_data_i` into all four lanes of `mem_wdata_o`. It sets exactly one bit of `mem_be_o`: byte offset 0 (bits 31:24) is `mem_be_o[3]`, offset 1 is bit 2, offset 2 is bit 1, and offset 3 (bits 7:0) is bit 0.
- R4: A halfword store drives the low halfword of `store_data_i` into both halves of `mem_wdata_o`. It sets `mem_be_o` to 4'b1100 when address bit 1 is 0 and to 4'b0011 when it is 1.
- R5: A word store drives `store_data_i` unchanged and sets `mem_be_o` to 4'b1111.
- R6: When `store_i` is 0, `mem_be_o` is 4'b0000 for every size.
- R7: A signed byte load returns the addressed lane of `mem_rdata_i`, using the same offset-to-lane mapping as R3, with its bit 7 copied into bits 31:8.
- R8: An unsigned byte load returns the addressed lane with bits 31:8 cleared. For example, lane value 0xFF loads as 0x000000FF, and as 0xFFFFFFFF when signed.
- R9: A halfword load takes bits 31:16 when address bit 1 is 0 and bits 15:0 otherwise. It sign-extends from bit 15, or zero-extends when `unsigned_i` is 1.
- R10: A word load returns `mem_rdata_i` unchanged, whatever the value of `unsigned_i`.
- R11: Size code 11 behaves exactly like a word access, both for alignment and for lane steering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| base_i | input | 32 | Base register value |
| imm_i | input | 16 | Signed displacement |
| size_i | input | 2 | Access size code |
| unsigned_i | input | 1 | Zero-extend narrow loads when 1 |
| store_i | input | 1 | 1 for a store, 0 for a load |
| store_data_i | input | 32 | Register value to store |
| mem_rdata_i | input | 32 | Word returned by memory |
| mem_addr_o | output | 32 | Aligned byte address to memory |
| mem_be_o | output | 4 | Byte write enables, bit 3 is the lowest address |
| mem_wdata_o | output | 32 | Lane-replicated write data |
| load_data_o | output | 32 | Extended load result |

## Verification
The hardest cases to reach are those where the displacement addition and the alignment mask interact. One is a negative displacement that borrows across the upper address bits. Another is a base near the top of the address space, where the sum wraps past zero and leaves a low offset that the mask must still clear. The bench picks base and displacement pairs that produce a borrow, a wrap and an odd offset. It then checks the masked address and the lane that is selected for each of them. The byte-lane mapping is swept over all four offsets, both for stores and for loads.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WIDE = 2'b11
  } acc_size_e;
endpackage

// File: rtl/lsa_addr_gen.sv
module lsa_addr_gen
  import lsa_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16,
  parameter int NBYTES = 4,
  localparam int OFF_W = $clog2(NBYTES)
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  acc_size_e         size_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [OFF_W-1:0]  off_o
);
  logic [ADDR_W-1:0] ea;
  logic [ADDR_W-1:0] keep_mask;

  always_comb begin
    ea = base_i + {{(ADDR_W-IMM_W){imm_i[IMM_W-1]}}, imm_i};
    keep_mask = '1;
    unique case (size_i)
      SZ_BYTE: keep_mask = '1;
      SZ_HALF: keep_mask[0] = 1'b0;
      default: keep_mask[OFF_W-1:0] = '0;
    endcase
    addr_o = ea & keep_mask;
    off_o  = addr_o[OFF_W-1:0];
    AST_ADDR_NEAR: assert ((ea - addr_o) < ADDR_W'(NBYTES)); // R2
    AST_WORD_LANE: assert (!(size_i inside {SZ_WORD, SZ_WIDE}) || off_o == '0); // R11
  end
endmodule

// File: rtl/lsa_store_lane.sv
module lsa_store_lane
  import lsa_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int NBYTES = DATA_W / 8,
  localparam int NHALF  = NBYTES / 2,
  localparam int OFF_W  = $clog2(NBYTES)
) (
  input  acc_size_e         size_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic              store_i,
  input  logic [DATA_W-1:0] sdata_i,
  output logic [DATA_W-1:0] wdata_o,
  output logic [NBYTES-1:0] be_o
);
  logic [NBYTES-1:0] be_raw;

  for (genvar k = 0; k < NBYTES; k++) begin : g_lane
    logic hit_byte, hit_half;
    assign hit_byte = (off_i == OFF_W'(k));
    assign hit_half = (off_i[OFF_W-1:1] == (OFF_W-1)'(k / 2));
    always_comb begin
      unique case (size_i)
        SZ_BYTE: be_raw[NBYTES-1-k] = hit_byte;
        SZ_HALF: be_raw[NBYTES-1-k] = hit_half;
        default: be_raw[NBYTES-1-k] = 1'b1;
      endcase
    end
  end

  always_comb begin
    unique case (size_i)
      SZ_BYTE: wdata_o = {NBYTES{sdata_i[7:0]}};
      SZ_HALF: wdata_o = {NHALF{sdata_i[15:0]}};
      default: wdata_o = sdata_i;
    endcase
    be_o = store_i ? be_raw : '0;
    AST_LOAD_NO_WRITE: assert (store_i || be_o == '0); // R6
    AST_BYTE_ONEHOT: assert (!(store_i && size_i == SZ_BYTE) || $countones(be_o) == 1); // R3
    AST_HALF_PAIR: assert (!(store_i && size_i == SZ_HALF) || $countones(be_o) == 2); // R4
  end
endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract
  import lsa_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int NBYTES = DATA_W / 8,
  localparam int NHALF  = NBYTES / 2,
  localparam int OFF_W  = $clog2(NBYTES)
) (
  input  acc_size_e         size_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic              unsigned_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] ldata_o
);
  logic [7:0]  byte_lane [NBYTES];
  logic [15:0] half_lane [NHALF];

  for (genvar k = 0; k < NBYTES; k++) begin : g_byte
    assign byte_lane[k] = rdata_i[DATA_W-1-8*k -: 8];
  end
  for (genvar j = 0; j < NHALF; j++) begin : g_half
    assign half_lane[j] = rdata_i[DATA_W-1-16*j -: 16];
  end

  logic [7:0]  sel_b;
  logic [15:0] sel_h;

  always_comb begin
    sel_b = byte_lane[off_i];
    sel_h = half_lane[off_i[OFF_W-1:1]];
    unique case (size_i)
      SZ_BYTE: ldata_o = {{(DATA_W-8){sel_b[7] & ~unsigned_i}}, sel_b};
      SZ_HALF: ldata_o = {{(DATA_W-16){sel_h[15] & ~unsigned_i}}, sel_h};
      default: ldata_o = rdata_i;
    endcase
    AST_ZERO_EXT_B: assert (!(unsigned_i && size_i == SZ_BYTE) || ldata_o[DATA_W-1:8] == '0); // R8
    AST_SIGN_EXT_H: assert (!(!unsigned_i && size_i == SZ_HALF)
                            || ldata_o[DATA_W-1:16] == {(DATA_W-16){ldata_o[15]}}); // R9
  end
endmodule

// File: rtl/lsa_unit.sv
module lsa_unit
  import lsa_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  localparam int NBYTES = DATA_W / 8,
  localparam int OFF_W  = $clog2(NBYTES)
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [1:0]        size_i,
  input  logic              unsigned_i,
  input  logic              store_i,
  input  logic [DATA_W-1:0] store_data_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [NBYTES-1:0] mem_be_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic [DATA_W-1:0] load_data_o
);
  acc_size_e        size;
  logic [OFF_W-1:0] off;

  assign size = acc_size_e'(size_i);

  lsa_addr_gen #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .NBYTES(NBYTES)) u_addr (
    .base_i (base_i),
    .imm_i  (imm_i),
    .size_i (size),
    .addr_o (mem_addr_o),
    .off_o  (off)
  );

  lsa_store_lane #(.DATA_W(DATA_W)) u_store (
    .size_i  (size),
    .off_i   (off),
    .store_i (store_i),
    .sdata_i (store_data_i),
    .wdata_o (mem_wdata_o),
    .be_o    (mem_be_o)
  );

  lsa_load_extract #(.DATA_W(DATA_W)) u_load (
    .size_i     (size),
    .off_i      (off),
    .unsigned_i (unsigned_i),
    .rdata_i    (mem_rdata_i),
    .ldata_o    (load_data_o)
  );

  always_comb begin
    AST_WORD_PASS: assert (store_i || !(size inside {SZ_WORD, SZ_WIDE})
                           || load_data_o == mem_rdata_i); // R10
  end
endmodule

// File: tb/lsa_unit_bench.sv
module lsa_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [31:0] base_i = '0;
  logic [15:0] imm_i = '0;
  logic [1:0]  size_i = '0;
  logic        unsigned_i = 1'b0;
  logic        store_i = 1'b0;
  logic [31:0] store_data_i = '0;
  logic [31:0] mem_rdata_i = '0;
  logic [31:0] mem_addr_o;
  logic [3:0]  mem_be_o;
  logic [31:0] mem_wdata_o;
  logic [31:0] load_data_o;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsa_unit u_lsa_unit (
    .base_i(base_i), .imm_i(imm_i), .size_i(size_i), .unsigned_i(unsigned_i),
    .store_i(store_i), .store_data_i(store_data_i), .mem_rdata_i(mem_rdata_i),
    .mem_addr_o(mem_addr_o), .mem_be_o(mem_be_o), .mem_wdata_o(mem_wdata_o),
    .load_data_o(load_data_o)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic drive(input logic [31:0] b, input logic [15:0] im, input logic [1:0] sz,
                       input logic uns, input logic st, input logic [31:0] sd,
                       input logic [31:0] rd);
    @(posedge clk);
    base_i = b; imm_i = im; size_i = sz; unsigned_i = uns;
    store_i = st; store_data_i = sd; mem_rdata_i = rd;
    @(negedge clk);
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    check("R6", "idle be", {28'd0, mem_be_o}, 32'h0);
    check("R1", "idle addr", mem_addr_o, 32'h0);
    check("R7", "idle load", load_data_o, 32'h0);
  endtask

  task automatic t_address;
    drive(32'd9, 16'd5, 2'b00, 1'b0, 1'b1, 32'h12345678, 32'h0);
    check("R1", "9+5 byte addr", mem_addr_o, 32'h0000000E);
    check("R3", "9+5 byte be", {28'd0, mem_be_o}, 32'h2);
    check("R3", "9+5 byte wdata", mem_wdata_o, 32'h78787878);
    drive(32'h00000100, 16'hFFF9, 2'b00, 1'b0, 1'b0, 32'h0, 32'h0);
    check("R1", "negative disp borrow", mem_addr_o, 32'h000000F9);
    drive(32'hFFFFFFFE, 16'h0005, 2'b00, 1'b0, 1'b0, 32'h0, 32'h0);
    check("R1", "wrap past zero", mem_addr_o, 32'h00000003);
    drive(32'hFFFFFFFE, 16'h0005, 2'b10, 1'b0, 1'b0, 32'h0, 32'h0);
    check("R2", "wrap word align", mem_addr_o, 32'h00000000);
  endtask

  task automatic t_align;
    drive(32'h00001000, 16'h0003, 2'b01, 1'b0, 1'b0, 32'h0, 32'h0);
    check("R2", "half clears bit0", mem_addr_o, 32'h00001002);
    drive(32'h00001000, 16'h0003, 2'b10, 1'b0, 1'b0, 32'h0, 32'h0);
    check("R2", "word clears bits1:0", mem_addr_o, 32'h00001000);
    drive(32'h00001000, 16'h0003, 2'b11, 1'b0, 1'b1, 32'hCAFEF00D, 32'h0);
    check("R11", "code 11 align", mem_addr_o, 32'h00001000);
    check("R11", "code 11 be", {28'd0, mem_be_o}, 32'hF);
    check("R11", "code 11 wdata", mem_wdata_o, 32'hCAFEF00D);
  endtask

  task automatic t_byte_store_sweep;
    for (int k = 0; k < 4; k++) begin
      drive(32'h00002000, 16'(k), 2'b00, 1'b0, 1'b1, 32'hAABBCC5A, 32'h0);
      check("R3", "byte store be", {28'd0, mem_be_o}, 32'(4'b1000 >> k));
      check("R3", "byte store wdata", mem_wdata_o, 32'h5A5A5A5A);
    end
  endtask

  task automatic t_half_word_store;
    drive(32'h00003000, 16'h0003, 2'b01, 1'b0, 1'b1, 32'h1234BEEF, 32'h0);
    check("R4", "half high-offset be", {28'd0, mem_be_o}, 32'h3);
    check("R4", "half wdata", mem_wdata_o, 32'hBEEFBEEF);
    drive(32'h00003000, 16'h0001, 2'b01, 1'b0, 1'b1, 32'h1234BEEF, 32'h0);
    check("R4", "half low-offset be", {28'd0, mem_be_o}, 32'hC);
    drive(32'h00003000, 16'h0002, 2'b10, 1'b0, 1'b1, 32'h89ABCDEF, 32'h0);
    check("R5", "word be", {28'd0, mem_be_o}, 32'hF);
    check("R5", "word wdata", mem_wdata_o, 32'h89ABCDEF);
  endtask

  task automatic t_loads_no_write;
    for (int s = 0; s < 4; s++) begin
      drive(32'h00004000, 16'h0001, 2'(s), 1'b0, 1'b0, 32'hFFFFFFFF, 32'h0);
      check("R6", "load be clear", {28'd0, mem_be_o}, 32'h0);
    end
  endtask

  task automatic t_byte_load_sweep;
    logic [31:0] rd;
    rd = 32'h80FF7F01;
    for (int k = 0; k < 4; k++) begin
      logic [7:0] b;
      b = 8'((rd >> (24 - 8*k)) & 32'hFF);
      drive(32'h00005000, 16'(k), 2'b00, 1'b0, 1'b0, 32'h0, rd);
      check("R7", "signed byte load", load_data_o, b[7] ? (32'hFFFFFF00 | 32'(b)) : 32'(b));
      drive(32'h00005000, 16'(k), 2'b00, 1'b1, 1'b0, 32'h0, rd);
      check("R8", "unsigned byte load", load_data_o, 32'(b));
    end
  endtask

  task automatic t_half_word_load;
    drive(32'h00006000, 16'h0001, 2'b01, 1'b0, 1'b0, 32'h0, 32'h80017FFE);
    check("R9", "signed half offset0", load_data_o, 32'hFFFF8001);
    drive(32'h00006000, 16'h0001, 2'b01, 1'b1, 1'b0, 32'h0, 32'h80017FFE);
    check("R9", "unsigned half offset0", load_data_o, 32'h00008001);
    drive(32'h00006000, 16'h0002, 2'b01, 1'b0, 1'b0, 32'h0, 32'h80017FFE);
    check("R9", "signed half offset2", load_data_o, 32'h00007FFE);
    drive(32'h00006000, 16'h0002, 2'b01, 1'b0, 1'b0, 32'h0, 32'h7FFE8001);
    check("R9", "signed half offset2 neg", load_data_o, 32'hFFFF8001);
    drive(32'h00006000, 16'h0003, 2'b10, 1'b1, 1'b0, 32'h0, 32'hF00DFACE);
    check("R10", "word load unsigned flag", load_data_o, 32'hF00DFACE);
    drive(32'h00006000, 16'h0000, 2'b10, 1'b0, 1'b0, 32'h0, 32'h80000001);
    check("R10", "word load signed", load_data_o, 32'h80000001);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    t_reset_state();
    t_address();
    t_align();
    t_byte_store_sweep();
    t_half_word_store();
    t_loads_no_write();
    t_byte_load_sweep();
    t_half_word_load();
    summary();
  end
endmodule